// File: doc/BRIEF.md
# Audio Bit and Master Clock Generator

This block derives the serial bit clock and an optional master clock for an I2S or TDM audio port from one already-selected source clock. Two half-period counters, one per output, toggle their output each time the programmed count is reached. A one-cycle strobe marks every rising bit-clock edge, so a downstream framer can shift data in the source-clock domain without sampling the divided clock itself. The block also reports how many bit clocks make up one stereo frame for the selected word width, which the frame-sync logic needs.

In slave operation the bit clock is not produced here. The strobe then follows the rising edges of an external bit clock after a two-stage synchronizer. A divider value written while a clock runs is taken up only when the current half period ends, so the outputs never show a short pulse.

Top module: `audio_clkgen`

## Requirements
- R1: In master mode with `en` high, `bclk` starts low and stays in each level for exactly `bclk_div`+1 source cycles, so its period is 2*(`bclk_div`+1). After the enabling edge k (k = 1, 2, ...), `bclk` equals (k / (`bclk_div`+1)) mod 2.
- R2: With `mclk_en` and `en` high and `mclk_div` = N not zero, `mclk` starts low and holds each level for N source cycles, so its period is 2N. After enabling edge k, `mclk` equals (k / N) mod 2.
- R3: With `mclk_div` = 0, `mclk` is the source clock itself: high while `clk` is high and low while `clk` is low.
- R4: With `mclk_en` low, `mclk` is low at all times.
- R5: With `en` low, `bclk`, `mclk` and `bclk_stb` are low from the following cycle on. A later enable restarts both clocks low from a cleared count, as stated in R1 and R2.
- R6: `frame_bits` equals 16*(`word_code`+1), where codes 0, 1, 2 and 3 select 8-, 16-, 24- and 32-bit words. This gives 16, 32, 48 or 64.
- R7: In master mode, `bclk_stb` is high for exactly one source cycle: the first cycle in which `bclk` is high after being low.
- R8: In slave mode, `bclk` stays low. `bclk_stb` pulses once for every rising edge of `ext_bclk` and is never high on two cycles in a row.
- R9: A new `bclk_div` value applied while running takes effect only at the end of the current half period. Every completed level of `bclk` then lasts the old or the new half period, never less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, already selected |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable for all generated clocks |
| slave_mode | input | 1 | 1: the bit clock comes from `ext_bclk` |
| mclk_en | input | 1 | Master clock output enable |
| mclk_div | input | 8 | Master clock divider (0 = bypass, N = divide by 2N) |
| bclk_div | input | 8 | Bit clock divider (half period = value+1) |
| word_code | input | 2 | Word width code (8/16/24/32 bits) |
| ext_bclk | input | 1 | External bit clock, used in slave mode |
| mclk | output | 1 | Master clock |
| bclk | output | 1 | Bit clock, low in slave mode |
| bclk_stb | output | 1 | One-cycle strobe on each rising bit-clock edge |
| frame_bits | output | 7 | Bit clocks per stereo frame |

## Verification
A wrong count or a missed reload inside a divider shows on `bclk` or `mclk` as a level that ends one or more cycles early or late. The cycle-by-cycle comparison exposes it within the first half period after enable. A strobe decoded from the wrong phase is off by one cycle against the first high cycle of `bclk`, and a stale bypass flag shows up as `mclk` failing to follow `clk` within the same cycle. A faulty synchronizer edge detector changes the strobe count over a burst of external edges.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;

    localparam int DIV_W   = 8;
    localparam int FRAME_W = 7;

    typedef enum logic [1:0] {
        WORD_8  = 2'd0,
        WORD_16 = 2'd1,
        WORD_24 = 2'd2,
        WORD_32 = 2'd3
    } word_code_e;

    typedef struct packed {
        logic phase;
        logic rise;
    } half_div_out_t;

    function automatic logic [FRAME_W-1:0] frame_len(input logic [1:0] code);
        logic [FRAME_W-1:0] words;
        words = FRAME_W'(code) + FRAME_W'(1);
        return words << 4;
    endfunction

endpackage

// File: rtl/half_div.sv
module half_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         term,
    output logic         phase,
    output logic         rise
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] act_q;

    assign term = run && (cnt_q == act_q);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            act_q <= div;
            phase <= 1'b0;
            rise  <= 1'b0;
        end else if (cnt_q == act_q) begin
            cnt_q <= '0;
            act_q <= div;
            phase <= ~phase;
            rise  <= ~phase;
        end else begin
            cnt_q <= cnt_q + W'(1);
            rise  <= 1'b0;
        end
    end
endmodule

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            rise <= 1'b0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], async_in};
            rise <= sh_q[STAGES-1] & ~sh_q[STAGES];
        end
    end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clk_pkg::*;
#(
    parameter int BDIV_W = DIV_W,
    parameter int MDIV_W = DIV_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                slave_mode,
    input  logic                mclk_en,
    input  logic [MDIV_W-1:0]   mclk_div,
    input  logic [BDIV_W-1:0]   bclk_div,
    input  logic [1:0]          word_code,
    input  logic                ext_bclk,
    output logic                mclk,
    output logic                bclk,
    output logic                bclk_stb,
    output logic [FRAME_W-1:0]  frame_bits
);
    localparam logic [MDIV_W-1:0] M_ONE = MDIV_W'(1);

    half_div_out_t b_out, m_out;
    logic b_run, m_run, b_term, m_term;
    logic m_zero, byp_q, ext_rise;
    logic [MDIV_W-1:0] m_half;

    assign b_run  = en && !slave_mode;
    assign m_run  = en && mclk_en;
    assign m_zero = (mclk_div == '0);
    assign m_half = m_zero ? '0 : (mclk_div - M_ONE);

    half_div #(.W(BDIV_W)) u_bdiv (
        .clk(clk), .rst(rst), .run(b_run), .div(bclk_div),
        .term(b_term), .phase(b_out.phase), .rise(b_out.rise)
    );

    half_div #(.W(MDIV_W)) u_mdiv (
        .clk(clk), .rst(rst), .run(m_run), .div(m_half),
        .term(m_term), .phase(m_out.phase), .rise(m_out.rise)
    );

    edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .async_in(ext_bclk), .rise(ext_rise)
    );

    // bypass flag reloads together with the divider, at half-period end
    always_ff @(posedge clk) begin
        if (rst || !m_run || m_term) byp_q <= m_zero;
    end

    assign mclk       = m_run && (byp_q ? clk : m_out.phase);
    assign bclk       = !slave_mode && b_out.phase;
    assign bclk_stb   = slave_mode ? (en && ext_rise) : b_out.rise;
    assign frame_bits = frame_len(word_code);

    logic unused_ok;
    assign unused_ok = b_term ^ m_out.rise;
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       slave_mode,
    input logic       mclk_en,
    input logic       mclk,
    input logic       bclk,
    input logic       bclk_stb,
    input logic [6:0] frame_bits
);
    p_mclk_gated_r4: assert property (@(posedge clk) disable iff (rst)
        !mclk_en |-> !mclk);

    p_all_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (!en && $past(!en)) |-> (!bclk && !mclk && !bclk_stb));

    p_frame_mult_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_bits[3:0] == 4'd0) && (frame_bits != 7'd0) && (frame_bits <= 7'd64));

    p_stb_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (bclk_stb && !slave_mode && $past(!slave_mode)) |-> (bclk && !$past(bclk)));

    p_stb_single_r8: assert property (@(posedge clk) disable iff (rst)
        bclk_stb |=> !bclk_stb);

    p_slave_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        slave_mode |-> !bclk);
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
    .clk(clk), .rst(rst), .en(en), .slave_mode(slave_mode),
    .mclk_en(mclk_en), .mclk(mclk), .bclk(bclk),
    .bclk_stb(bclk_stb), .frame_bits(frame_bits)
);

// File: tb/test_audio_clkgen.sv
module test_audio_clkgen;
    logic clk = 1'b0;
    logic rst, en, slave_mode, mclk_en, ext_bclk;
    logic [7:0] mclk_div, bclk_div;
    logic [1:0] word_code;
    logic mclk, bclk, bclk_stb;
    logic [6:0] frame_bits;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    audio_clkgen i_audio_clkgen (
        .clk(clk), .rst(rst), .en(en), .slave_mode(slave_mode),
        .mclk_en(mclk_en), .mclk_div(mclk_div), .bclk_div(bclk_div),
        .word_code(word_code), .ext_bclk(ext_bclk), .mclk(mclk),
        .bclk(bclk), .bclk_stb(bclk_stb), .frame_bits(frame_bits)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // disable, load config, enable, then compare every cycle
    task automatic run_cfg(input int d, input int n);
        int bad_b = 0, bad_m = 0, bad_s = 0, bad_off = 0;
        @(negedge clk);
        en = 1'b0; bclk_div = 8'(d); mclk_div = 8'(n); mclk_en = 1'b1;
        repeat (2) begin
            @(negedge clk);
            if (bclk || mclk || bclk_stb) bad_off++;
        end
        check(bad_off == 0, "R5 off", bad_off, 0);
        en = 1'b1;
        for (int k = 1; k <= 4 * (d + 1) + 4 * n + 6; k++) begin
            @(negedge clk);
            if (bclk !== 1'((k / (d + 1)) % 2)) bad_b++;
            if (mclk !== 1'((k / n) % 2)) bad_m++;
            if (bclk_stb !== ((k % (d + 1) == 0) && ((k / (d + 1)) % 2 == 1))) bad_s++;
        end
        check(bad_b == 0, "R1 bclk", bad_b, 0);
        check(bad_m == 0, "R2 mclk", bad_m, 0);
        check(bad_s == 0, "R7 stb", bad_s, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt, len, bad;
        logic prev;
        rst = 1'b1; en = 1'b0; slave_mode = 1'b0; mclk_en = 1'b0;
        mclk_div = 8'd0; bclk_div = 8'd0; word_code = 2'd0; ext_bclk = 1'b0;
        repeat (3) @(negedge clk);
        check(!bclk && !mclk && !bclk_stb, "R5 reset", {bclk, mclk, bclk_stb}, 0);
        rst = 1'b0;

        // R6: frame length per word code
        for (int c = 0; c < 4; c++) begin
            word_code = 2'(c);
            #1;
            check(frame_bits == 7'(16 * (c + 1)), "R6 frame", frame_bits, 16 * (c + 1));
        end

        // R1 R2 R5 R7: sweep of divider settings
        for (int d = 0; d < 6; d++)
            for (int n = 1; n < 5; n++)
                run_cfg(d, n);

        // R3: bypass follows the source clock
        @(negedge clk);
        en = 1'b0; mclk_div = 8'd0; mclk_en = 1'b1; bclk_div = 8'd1;
        @(negedge clk); en = 1'b1;
        bad = 0;
        repeat (10) begin
            @(posedge clk); #2;
            if (mclk !== 1'b1) bad++;
            @(negedge clk); #1;
            if (mclk !== 1'b0) bad++;
        end
        check(bad == 0, "R3 bypass", bad, 0);

        // R4: master clock held low while its enable is clear
        mclk_en = 1'b0; mclk_div = 8'd2;
        bad = 0;
        repeat (10) begin
            @(posedge clk); #2;
            if (mclk !== 1'b0) bad++;
            @(negedge clk); #1;
            if (mclk !== 1'b0) bad++;
        end
        check(bad == 0, "R4 gated", bad, 0);

        // R9: change of bit clock divider while running
        @(negedge clk);
        en = 1'b0; bclk_div = 8'd2;
        @(negedge clk); en = 1'b1;
        prev = 1'b0; len = 0; bad = 0; cnt = 0;
        for (int k = 1; k <= 80; k++) begin
            @(negedge clk);
            if (k == 17) bclk_div = 8'd5;
            len++;
            if (bclk !== prev) begin
                if (!(len == 3 || len == 6)) bad++;
                cnt++;
                len = 0;
                prev = bclk;
            end
        end
        check(bad == 0 && cnt > 10, "R9 no runt", bad, 0);

        // R8: slave mode follows external edges
        @(negedge clk);
        slave_mode = 1'b1; bclk_div = 8'd0;
        repeat (3) @(negedge clk);
        cnt = 0; bad = 0;
        for (int p = 0; p < 5; p++) begin
            ext_bclk = 1'b1;
            repeat (6) begin
                @(negedge clk);
                if (bclk_stb) cnt++;
                if (bclk) bad++;
            end
            ext_bclk = 1'b0;
            repeat (6) begin
                @(negedge clk);
                if (bclk_stb) cnt++;
                if (bclk) bad++;
            end
        end
        check(cnt == 5, "R8 slave strobes", cnt, 5);
        check(bad == 0, "R8 slave bclk low", bad, 0);

        // R5: disabled slave ignores external edges
        en = 1'b0; cnt = 0;
        for (int p = 0; p < 3; p++) begin
            ext_bclk = 1'b1;
            repeat (5) begin @(negedge clk); if (bclk_stb) cnt++; end
            ext_bclk = 1'b0;
            repeat (5) begin @(negedge clk); if (bclk_stb) cnt++; end
        end
        check(cnt == 0, "R5 slave off", cnt, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule